// File: doc/BRIEF.md
# Register-Mapped Signed Integer Divider

This block is a signed divide unit that software drives through a small 32-bit register bus. Software places a 64-bit numerator and a 64-bit denominator in two pairs of word registers and picks an operand-width mode in a control word. Every write to an operand or to the control word starts a fresh computation and raises a busy flag. When the engine finishes, it writes a 64-bit quotient and a 64-bit remainder into read-only result words and drops busy. Software polls busy and then reads the results.

The engine is a restoring divider working on operand magnitudes, one quotient bit per cycle for a fixed 64 iterations, followed by a sign fix-up cycle. A zero divisor and the single overflowing quotient (most negative numerator over minus one) produce fixed results and raise a shared error flag. Every operation, the special ones included, takes the same number of cycles.

Top module: `sdiv_regs`

## Requirements
- R1: After reset every register reads zero. Word addresses: 0 control, 1 numerator low, 2 numerator high, 3 denominator low, 4 denominator high, 5 quotient low, 6 quotient high, 7 remainder low, 8 remainder high; unmapped addresses read zero.
- R2: Control bits [1:0] hold the mode: 0 sign-extends both numerator and denominator from their low 32 bits; 1 and 3 use the full 64-bit numerator and sign-extend the denominator from its low 32 bits; 2 uses both full 64-bit values.
- R3: A write to word 0, 1, 2, 3 or 4 sets busy (control bit 15) from the next cycle and restarts the engine, also when a computation is already running.
- R4: Busy clears at the 66th rising edge after the edge that accepted the last starting write, and results are written at that same edge.
- R5: The error flag (control bit 14) is set by a zero divisor or the overflow case and cleared by any normal division; it changes only when results are written.
- R6: With a zero effective denominator the remainder becomes the effective numerator, and the quotient becomes 1 if that numerator is negative, else 0.
- R7: A normal division truncates the quotient toward zero, and the remainder takes the sign of the numerator.
- R8: While busy, the result words and the error flag keep their previous values.
- R9: With an effective numerator of 0x8000_0000_0000_0000 and a denominator of -1, the quotient becomes that numerator and the remainder words keep their old value.
- R10: A starting write accepted at the same edge the engine completes takes priority: that completion is discarded, busy stays set and the results keep their old values.
- R11: Writes to result words and to unmapped addresses change no register and start nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the addressed word |

## Verification
The two functions that can meet in one cycle are engine completion and a starting write from software. The bench writes the control word, waits exactly 65 edges and issues a second control write so that it is accepted at the completion edge; it then judges that busy is still set, that the quotient still holds the value from before the first write, and that the final results match the mode of the second write after a full 66-edge run. A related restart test rewrites the control word in the middle of a run and checks that the latency is counted from the second write.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

    // Register word indices on the bus
    localparam int IDX_CTRL = 0;
    localparam int IDX_NLO  = 1;
    localparam int IDX_NHI  = 2;
    localparam int IDX_DLO  = 3;
    localparam int IDX_DHI  = 4;
    localparam int IDX_QLO  = 5;
    localparam int IDX_QHI  = 6;
    localparam int IDX_RLO  = 7;
    localparam int IDX_RHI  = 8;

    // Control word bit positions
    localparam int BUSY_BIT = 15;
    localparam int ERR_BIT  = 14;
    localparam int MODE_W   = 2;

    // Operand-width modes
    localparam logic [MODE_W-1:0] MODE_32_32 = 2'd0;
    localparam logic [MODE_W-1:0] MODE_64_64 = 2'd2;

    typedef enum logic [1:0] {
        KIND_NORMAL = 2'd0,
        KIND_ZERO   = 2'd1,
        KIND_OVF    = 2'd2
    } div_kind_e;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_RUN  = 2'd1,
        ENG_FIX  = 2'd2
    } eng_state_e;

endpackage

// File: rtl/sdiv_prep.sv
module sdiv_prep
    import sdiv_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [W-1:0]      num_raw,
    input  logic [W-1:0]      den_raw,
    output logic [W-1:0]      eff_num,
    output logic [W-1:0]      eff_den,
    output div_kind_e         kind
);

    localparam int H = W / 2;
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MINUS_ONE = {W{1'b1}};

    always_comb begin
        if (mode == MODE_32_32) begin
            eff_num = {{H{num_raw[H-1]}}, num_raw[H-1:0]};
        end else begin
            eff_num = num_raw;
        end

        if (mode == MODE_64_64) begin
            eff_den = den_raw;
        end else begin
            eff_den = {{H{den_raw[H-1]}}, den_raw[H-1:0]};
        end

        if (eff_den == '0) begin
            kind = KIND_ZERO;
        end else if (eff_num == MOST_NEG && eff_den == MINUS_ONE) begin
            kind = KIND_OVF;
        end else begin
            kind = KIND_NORMAL;
        end
    end

endmodule

// File: rtl/sdiv_core.sv
module sdiv_core
    import sdiv_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    input  div_kind_e    kind_i,
    output logic         done_o,
    output logic [W-1:0] quot_o,
    output logic [W-1:0] rem_o,
    output logic         rem_wr_o,
    output logic         err_o
);

    localparam int ITERS = W;
    localparam int CW    = $clog2(ITERS);
    localparam logic [CW-1:0] LAST = CW'(ITERS - 1);
    localparam logic [W-1:0]  ONE  = {{(W-1){1'b0}}, 1'b1};

    typedef struct packed {
        eng_state_e  st;
        logic [CW-1:0] cnt;
        logic [W-1:0]  r;
        logic [W-1:0]  q;
        logic [W-1:0]  d;
        logic [W-1:0]  num;
        logic          neg_n;
        logic          neg_d;
        div_kind_e     kind;
    } eng_t;

    eng_t eng_d, eng_q;
    logic [W:0] r_sh;

    always_comb begin
        eng_d = eng_q;
        r_sh  = {eng_q.r, eng_q.q[W-1]};
        case (eng_q.st)
            ENG_RUN: begin
                if (r_sh >= {1'b0, eng_q.d}) begin
                    eng_d.r = r_sh[W-1:0] - eng_q.d;
                    eng_d.q = {eng_q.q[W-2:0], 1'b1};
                end else begin
                    eng_d.r = r_sh[W-1:0];
                    eng_d.q = {eng_q.q[W-2:0], 1'b0};
                end
                eng_d.cnt = eng_q.cnt + 1'b1;
                if (eng_q.cnt == LAST) begin
                    eng_d.st = ENG_FIX;
                end
            end
            ENG_FIX: begin
                eng_d.st = ENG_IDLE;
            end
            default: begin
                eng_d.st = ENG_IDLE;
            end
        endcase

        if (start_i) begin
            eng_d.st    = ENG_RUN;
            eng_d.cnt   = '0;
            eng_d.r     = '0;
            eng_d.neg_n = num_i[W-1];
            eng_d.neg_d = den_i[W-1];
            eng_d.q     = num_i[W-1] ? (~num_i + ONE) : num_i;
            eng_d.d     = den_i[W-1] ? (~den_i + ONE) : den_i;
            eng_d.num   = num_i;
            eng_d.kind  = kind_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{st: ENG_IDLE, kind: KIND_NORMAL, default: '0};
        end else begin
            eng_q <= eng_d;
        end
    end

    // Result packing and sign fix-up
    always_comb begin
        done_o = (eng_q.st == ENG_FIX) && !start_i;
        case (eng_q.kind)
            KIND_ZERO: begin
                quot_o   = eng_q.neg_n ? ONE : '0;
                rem_o    = eng_q.num;
                rem_wr_o = 1'b1;
                err_o    = 1'b1;
            end
            KIND_OVF: begin
                quot_o   = eng_q.num;
                rem_o    = '0;
                rem_wr_o = 1'b0;
                err_o    = 1'b1;
            end
            default: begin
                quot_o   = (eng_q.neg_n ^ eng_q.neg_d) ? (~eng_q.q + ONE) : eng_q.q;
                rem_o    = eng_q.neg_n ? (~eng_q.r + ONE) : eng_q.r;
                rem_wr_o = 1'b1;
                err_o    = 1'b0;
            end
        endcase
    end

    AST_FIX_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st == ENG_FIX) |-> ($past(eng_q.st) == ENG_RUN)); // R4

    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st == ENG_FIX && eng_q.kind == KIND_NORMAL) |-> (eng_q.r < eng_q.d)); // R7

endmodule

// File: rtl/sdiv_regs.sv
module sdiv_regs
    import sdiv_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata
);

    localparam int W = 2 * BUS_W;
    localparam int CTRL_PAD = BUS_W - BUSY_BIT - 1;
    localparam int MID_PAD  = ERR_BIT - MODE_W;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [W-1:0]      num;
        logic [W-1:0]      den;
        logic [W-1:0]      quot;
        logic [W-1:0]      rem;
        logic              busy;
        logic              err;
        logic              start;
    } regs_t;

    regs_t regs_d, regs_q;

    logic          wr_kick;
    logic [W-1:0]  eff_num, eff_den;
    div_kind_e     kind;
    logic          core_done, core_rem_wr, core_err;
    logic [W-1:0]  core_quot, core_rem;

    sdiv_prep #(.W(W)) u_prep (
        .mode    (regs_q.mode),
        .num_raw (regs_q.num),
        .den_raw (regs_q.den),
        .eff_num (eff_num),
        .eff_den (eff_den),
        .kind    (kind)
    );

    sdiv_core #(.W(W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (regs_q.start),
        .num_i    (eff_num),
        .den_i    (eff_den),
        .kind_i   (kind),
        .done_o   (core_done),
        .quot_o   (core_quot),
        .rem_o    (core_rem),
        .rem_wr_o (core_rem_wr),
        .err_o    (core_err)
    );

    always_comb begin
        wr_kick = bus_wr && (bus_addr == ADDR_W'(IDX_CTRL) || bus_addr == ADDR_W'(IDX_NLO) ||
                             bus_addr == ADDR_W'(IDX_NHI)  || bus_addr == ADDR_W'(IDX_DLO) ||
                             bus_addr == ADDR_W'(IDX_DHI));
    end

    always_comb begin
        regs_d       = regs_q;
        regs_d.start = wr_kick;
        if (bus_wr) begin
            case (bus_addr)
                ADDR_W'(IDX_CTRL): regs_d.mode            = bus_wdata[MODE_W-1:0];
                ADDR_W'(IDX_NLO):  regs_d.num[BUS_W-1:0]  = bus_wdata;
                ADDR_W'(IDX_NHI):  regs_d.num[W-1:BUS_W]  = bus_wdata;
                ADDR_W'(IDX_DLO):  regs_d.den[BUS_W-1:0]  = bus_wdata;
                ADDR_W'(IDX_DHI):  regs_d.den[W-1:BUS_W]  = bus_wdata;
                default: ;
            endcase
        end
        if (wr_kick) begin
            regs_d.busy = 1'b1;
        end else if (core_done) begin
            regs_d.busy = 1'b0;
            regs_d.quot = core_quot;
            regs_d.err  = core_err;
            if (core_rem_wr) begin
                regs_d.rem = core_rem;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        case (bus_addr)
            ADDR_W'(IDX_CTRL): bus_rdata = {{CTRL_PAD{1'b0}}, regs_q.busy, regs_q.err,
                                            {MID_PAD{1'b0}}, regs_q.mode};
            ADDR_W'(IDX_NLO):  bus_rdata = regs_q.num[BUS_W-1:0];
            ADDR_W'(IDX_NHI):  bus_rdata = regs_q.num[W-1:BUS_W];
            ADDR_W'(IDX_DLO):  bus_rdata = regs_q.den[BUS_W-1:0];
            ADDR_W'(IDX_DHI):  bus_rdata = regs_q.den[W-1:BUS_W];
            ADDR_W'(IDX_QLO):  bus_rdata = regs_q.quot[BUS_W-1:0];
            ADDR_W'(IDX_QHI):  bus_rdata = regs_q.quot[W-1:BUS_W];
            ADDR_W'(IDX_RLO):  bus_rdata = regs_q.rem[BUS_W-1:0];
            ADDR_W'(IDX_RHI):  bus_rdata = regs_q.rem[W-1:BUS_W];
            default:           bus_rdata = '0;
        endcase
    end

    AST_BUSY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_kick |=> regs_q.busy); // R3

    AST_BUSY_FALL_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(regs_q.busy) |-> $past(core_done)); // R4

    AST_RESULTS_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.busy && $past(regs_q.busy)) |-> ($stable(regs_q.quot) && $stable(regs_q.rem))); // R8

    AST_ERR_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.busy && $past(regs_q.busy)) |-> $stable(regs_q.err)); // R5

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_kick && core_done) |=> (regs_q.busy && $stable(regs_q.quot))); // R10

endmodule

// File: tb/sdiv_regs_bench.sv
module sdiv_regs_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int fails  = 0;

    logic [63:0] cur_quot = '0;
    logic [63:0] cur_rem  = '0;

    localparam int LATENCY = 66;

    always #5 clk = ~clk;

    sdiv_regs u_sdiv_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input int addr, input logic [31:0] data);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = 4'(addr);
        bus_wdata = data;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input int addr, output logic [31:0] data);
        bus_addr = 4'(addr);
        #1;
        data = bus_rdata;
    endtask

    task automatic read64(input int lo_addr, output logic [63:0] v);
        logic [31:0] lo, hi;
        bus_read(lo_addr, lo);
        bus_read(lo_addr + 1, hi);
        v = {hi, lo};
    endtask

    // Counts edges after the last starting write until busy reads clear
    task automatic wait_idle(output int edges);
        logic [31:0] c;
        edges = -1;
        for (int i = 1; i <= 400; i++) begin
            @(posedge clk);
            #1;
            bus_read(0, c);
            if (!c[15]) begin
                edges = i;
                break;
            end
        end
    endtask

    function automatic void model(input logic [1:0] mode, input logic [63:0] nr,
                                  input logic [63:0] dr, output logic [63:0] q,
                                  output logic [63:0] r, output bit rw, output bit err);
        logic signed [63:0] n, d;
        n = (mode == 2'd0) ? {{32{nr[31]}}, nr[31:0]} : nr;
        d = (mode == 2'd2) ? dr : {{32{dr[31]}}, dr[31:0]};
        if (d == 0) begin
            q = (n < 0) ? 64'd1 : 64'd0; r = n; rw = 1; err = 1;
        end else if (n == 64'h8000_0000_0000_0000 && d == -64'sd1) begin
            q = n; r = '0; rw = 0; err = 1;
        end else begin
            q = n / d; r = n % d; rw = 1; err = 0;
        end
    endfunction

    // Loads operands and mode, then checks busy, held results, latency and outputs
    task automatic run_case(input string req, input logic [1:0] mode,
                            input logic [63:0] n, input logic [63:0] d);
        logic [63:0] eq, er, aq, ar;
        logic [31:0] c;
        bit rw, err;
        int lat;
        model(mode, n, d, eq, er, rw, err);
        if (!rw) er = cur_rem;
        bus_write(1, n[31:0]);
        bus_write(2, n[63:32]);
        bus_write(3, d[31:0]);
        bus_write(4, d[63:32]);
        bus_write(0, {30'd0, mode});
        bus_read(0, c);
        chk("R3", {req, " busy after write"}, 64'(c[15]), 64'd1);
        read64(5, aq);
        chk("R8", {req, " quotient held while busy"}, aq, cur_quot);
        wait_idle(lat);
        chk("R4", {req, " latency"}, 64'(lat), 64'(LATENCY));
        read64(5, aq);
        read64(7, ar);
        bus_read(0, c);
        chk(req, "quotient", aq, eq);
        chk(req, "remainder", ar, er);
        chk("R5", {req, " error flag"}, 64'(c[14]), 64'(err));
        chk("R2", {req, " mode readback"}, 64'(c[1:0]), 64'(mode));
        cur_quot = eq;
        cur_rem  = er;
    endtask

    task automatic test_reset;
        logic [31:0] v;
        for (int a = 0; a < 16; a++) begin
            bus_read(a, v);
            chk("R1", $sformatf("reset word %0d", a), 64'(v), 64'd0);
        end
    endtask

    task automatic test_normal;
        run_case("R7", 2'd0, 64'h1234_5678_FFFF_FFF9, 64'hABCD_0000_FFFF_FFFE); // -7 / -2
        run_case("R7", 2'd0, 64'h0000_0000_0000_0064, 64'hFFFF_FFFF_FFFF_FFF9); // 100 / -7
        run_case("R2", 2'd1, 64'hFFFF_FF00_0000_1234, 64'hDEAD_0000_FFFF_FFFD);
        run_case("R2", 2'd3, 64'h0123_4567_89AB_CDEF, 64'hDEAD_0000_FFFF_FFFD);
        run_case("R2", 2'd2, 64'h0123_4567_89AB_CDEF, 64'hDEAD_0000_FFFF_FFFD);
        run_case("R7", 2'd2, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0003);
        run_case("R7", 2'd2, 64'h0000_0000_0000_0005, 64'h7FFF_FFFF_FFFF_FFFF);
    endtask

    task automatic test_special;
        run_case("R6", 2'd0, 64'h7777_7777_FFFF_FFF7, 64'h5555_5555_0000_0000); // -9 / 0
        run_case("R6", 2'd1, 64'h0000_0001_0000_0000, 64'h0000_0009_0000_0000); // den low 0
        run_case("R7", 2'd1, 64'h0000_0000_0000_0010, 64'h0000_0000_0000_0004); // clears err
        run_case("R9", 2'd2, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF);
        run_case("R7", 2'd2, 64'h0000_0000_0000_0011, 64'h0000_0000_0000_0005);
        run_case("R9", 2'd1, 64'h8000_0000_0000_0000, 64'h0000_0000_FFFF_FFFF);
    endtask

    task automatic test_restart;
        logic [63:0] aq, eq, er;
        bit rw, err;
        int lat;
        bus_write(1, 32'd1000);
        bus_write(2, 32'd0);
        bus_write(3, 32'd7);
        bus_write(4, 32'd0);
        repeat (30) @(posedge clk);
        #1;
        read64(5, aq);
        chk("R8", "restart quotient held mid-run", aq, cur_quot);
        bus_write(3, 32'd9);
        wait_idle(lat);
        chk("R3", "restart latency from last write", 64'(lat), 64'(LATENCY));
        model(2'd1, 64'd1000, 64'd9, eq, er, rw, err);
        read64(5, aq);
        chk("R3", "restart quotient uses new operand", aq, eq);
        cur_quot = eq;
        cur_rem  = er;
    endtask

    task automatic test_collision;
        logic [63:0] a, b, eq, er, aq;
        logic [31:0] c;
        bit rw, err;
        int lat;
        a = 64'h0000_0003_0000_0064;
        b = 64'h0000_0001_0000_0004;
        run_case("R7", 2'd2, a, b);
        bus_write(0, 32'd0);
        repeat (LATENCY - 1) @(posedge clk);
        bus_write(0, 32'd1);
        bus_read(0, c);
        chk("R10", "busy kept on collision", 64'(c[15]), 64'd1);
        read64(5, aq);
        chk("R10", "completion discarded", aq, cur_quot);
        wait_idle(lat);
        chk("R10", "latency after collision", 64'(lat), 64'(LATENCY));
        model(2'd1, a, b, eq, er, rw, err);
        read64(5, aq);
        chk("R10", "quotient from second write", aq, eq);
        cur_quot = eq;
        cur_rem  = er;
    endtask

    task automatic test_ro_writes;
        logic [63:0] aq;
        logic [31:0] c;
        bus_write(5, 32'hDEAD_BEEF);
        bus_write(8, 32'h1234_5678);
        bus_write(12, 32'hFFFF_FFFF);
        bus_read(0, c);
        chk("R11", "no start from result write", 64'(c[15]), 64'd0);
        read64(5, aq);
        chk("R11", "quotient unchanged", aq, cur_quot);
        read64(7, aq);
        chk("R11", "remainder unchanged", aq, cur_rem);
        bus_read(12, c);
        chk("R11", "unmapped reads zero", 64'(c), 64'd0);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        test_reset;
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        test_reset;
        test_normal;
        test_special;
        test_restart;
        test_collision;
        test_ro_writes;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule